// File: doc/BRIEF.md
# Egress Parity Check and Packet Nullifier

This block sits on the transmit side of a switch port, at the point where a packet leaves the switch core and enters the link layer. Each packet arrives as a stream of 32-bit words, and every word carries one even-parity bit that was produced when the packet entered the switch and was kept up to date on the way through. The block checks the parity of every word. In the same cycle it folds the word into the 32-bit link CRC, so the CRC is computed alongside the parity check and no extra pass over the packet is needed.

On the last word of a packet the block presents the CRC on a sideband bus, next to that word. If every word of the packet was clean, it presents the true CRC and marks a normal end. If any word failed parity, it nullifies the packet: it presents the bitwise inverse of the computed CRC and raises the bad-end marker, so that the link partner discards the packet.

A nullified packet also raises a one-cycle request for a non-fatal error message, but only when reporting is enabled. It also adds one to a 16-bit saturating error count that software can read and clear. Each bad packet gives exactly one request and one increment, however many of its words are corrupt.

Top module: `egress_parity_nullifier`

## Requirements
- R1: Each input word with `in_valid` high appears on `out_data` one clock later, with `out_valid` high and `out_sop` and `out_last` copying `in_sop` and `in_eop`. `out_valid`, `out_sop` and `out_last` are low in any cycle that follows a cycle with `in_valid` low.
- R2: A word is clean when the XOR of its 32 data bits and its parity bit is 0 (even parity over 33 bits). Otherwise it is a parity failure.
- R3: When `out_last` is high for a packet with no parity failure, `out_edb` is 0 and `out_crc` is the packet CRC. The packet CRC uses the reflected polynomial 0xEDB88320 and starts from 0xFFFFFFFF at the start-of-packet word. Each word is consumed from data bit 0 up to bit 31, and the result is the final state complemented.
- R4: When `out_last` is high for a packet with at least one parity failure, `out_edb` is 1 and `out_crc` is the bitwise inverse of the R3 value.
- R5: The failure state of a packet is set by its first bad word and held to its last word. A start-of-packet word clears it, so a bad packet has no effect on the end marker or CRC of the packet after it.
- R6: `msg_req` is high for exactly the one cycle in which `out_last` is high for a nullified packet, and only if `rpt_en` was high with that packet's last word. It is low in all other cycles.
- R7: `err_count` rises by exactly one per nullified packet, visible in the same cycle as that packet's `out_last`, whether one word or many words failed.
- R8: `err_count` saturates at 0xFFFF, and further nullified packets leave it at 0xFFFF.
- R9: `cnt_clr` high sets `err_count` to 0 on the next clock. A clear takes priority over an increment in the same cycle.
- R10: After a synchronous active-low reset, `out_valid`, `out_last`, `out_edb`, `msg_req` are 0 and `err_count` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | Input word is the first of a packet |
| in_eop | input | 1 | Input word is the last of a packet |
| in_data | input | 32 | Input data word |
| in_par | input | 1 | Even-parity bit of the input word |
| rpt_en | input | 1 | Control: enable non-fatal error message requests |
| cnt_clr | input | 1 | Control: software write that clears the error count |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | Output word is the first of a packet |
| out_last | output | 1 | Output word is the last; CRC and end marker valid |
| out_data | output | 32 | Output data word |
| out_crc | output | 32 | CRC to transmit, valid with out_last |
| out_edb | output | 1 | Bad-end marker: packet nullified, valid with out_last |
| msg_req | output | 1 | One-cycle non-fatal error message request |
| err_count | output | 16 | Saturating count of nullified packets |

## Verification
Directed packets come first. A clean multi-word packet tests the plain CRC against its inverse. A packet with several bad words tests the single request and single count step against per-word counting. A bad packet with reporting disabled tests message gating apart from nullification. A clean packet straight after a bad one tests the sticky flag against clearing at start of packet. Single-word packets run back to back with a clear on a bad end, and a run of more than 65535 bad packets, cover clear priority and saturation. Random packets of one to eight words, with random corrupt parity, random gaps and random reporting enable, then compare data, CRC, end marker, request and count on every cycle against a bench model.

// File: rtl/egp_pkg.sv
// Package egp_pkg
// Shared widths and the link CRC step used by the egress parity block.
// Assumes 32-bit words and a reflected CRC-32 consumed from bit 0 upward.
package egp_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned CRC_W    = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

    // Fold one data word into a running CRC state, bit 0 first.
    function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] state,
                                                  input logic [WORD_W-1:0] word);
        logic [CRC_W-1:0] c;
        c = state;
        for (int i = 0; i < WORD_W; i++) begin
            if (c[0] ^ word[i]) c = (c >> 1) ^ CRC_POLY;
            else                c = c >> 1;
        end
        return c;
    endfunction
endpackage

// File: rtl/egp_parity_check.sv
// Module egp_parity_check
// Combinational even-parity check of one word. The word is split into
// lanes, each lane is reduced on its own and the lane results are combined
// with the parity bit. Assumes DATA_W is a multiple of LANE_W.
module egp_parity_check #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par,
    output logic              bad
);
    localparam int unsigned LANES = DATA_W / LANE_W;

    logic [LANES-1:0] lane_par;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Reduce one lane to its parity.
        assign lane_par[g] = ^data[g*LANE_W +: LANE_W];
    end

    // Even parity over data and parity bit: any odd total is a failure.
    assign bad = (^lane_par) ^ par;
endmodule

// File: rtl/egp_crc_accum.sv
// Module egp_crc_accum
// Running link CRC over the words of a packet. crc_next is the state after
// folding in the current word, restarted from the seed at start of packet.
// Assumes well-formed packets (start word first, last word ends the packet).
module egp_crc_accum
    import egp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              sop,
    input  logic [WORD_W-1:0] data,
    output logic [CRC_W-1:0]  crc_next
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] base;

    // Select the starting state and fold the current word.
    always_comb begin
        base     = sop ? CRC_SEED : crc_q;
        crc_next = crc_fold(base, data);
    end

    // Hold the running state between words of a packet.
    always_ff @(posedge clk) begin
        if (!rst_n)     crc_q <= CRC_SEED;
        else if (valid) crc_q <= crc_next;
    end
endmodule

// File: rtl/egp_err_counter.sv
// Module egp_err_counter
// Saturating count of nullified packets. A clear wins over an increment
// in the same cycle. Assumes at most one increment per cycle.
module egp_err_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Clear, saturate, or step the count.
    always_ff @(posedge clk) begin
        if (!rst_n)                       count <= '0;
        else if (clr)                     count <= '0;
        else if (inc && count != CNT_MAX) count <= count + 1'b1;
    end

    AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && !clr) |=> (count == CNT_MAX)); // R8
    AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0)); // R9
    AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1))); // R7
endmodule

// File: rtl/egress_parity_nullifier.sv
// Module egress_parity_nullifier
// Egress stage: passes words through with one cycle of latency, checks
// parity per word, computes the link CRC alongside, and on the last word
// presents either the true CRC with a normal end or the inverted CRC with
// the bad-end marker. A nullified packet raises one message request (when
// enabled) and one counter step. Assumes well-formed packets.
module egress_parity_nullifier
    import egp_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_par,
    input  logic              rpt_en,
    input  logic              cnt_clr,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_last,
    output logic [WORD_W-1:0] out_data,
    output logic [CRC_W-1:0]  out_crc,
    output logic              out_edb,
    output logic              msg_req,
    output logic [CNT_W-1:0]  err_count
);
    logic             word_bad;
    logic             pkt_bad_q;
    logic             pkt_bad_now;
    logic             end_bad;
    logic [CRC_W-1:0] crc_next;

    egp_parity_check #(.DATA_W(WORD_W), .LANE_W(LANE_W)) u_par (
        .data (in_data),
        .par  (in_par),
        .bad  (word_bad)
    );

    egp_crc_accum u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (in_valid),
        .sop      (in_sop),
        .data     (in_data),
        .crc_next (crc_next)
    );

    // Failure state including the current word; start of packet drops history.
    always_comb begin
        pkt_bad_now = word_bad | (pkt_bad_q & ~in_sop);
        end_bad     = in_valid & in_eop & pkt_bad_now;
    end

    // Sticky per-packet failure flag.
    always_ff @(posedge clk) begin
        if (!rst_n)        pkt_bad_q <= 1'b0;
        else if (in_valid) pkt_bad_q <= pkt_bad_now;
    end

    // Register the outgoing word, its CRC and its end marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
            out_crc   <= '0;
            out_edb   <= 1'b0;
            msg_req   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_sop   <= in_valid & in_sop;
            out_last  <= in_valid & in_eop;
            out_data  <= in_data;
            out_crc   <= pkt_bad_now ? crc_next : ~crc_next;
            out_edb   <= end_bad;
            msg_req   <= end_bad & rpt_en;
        end
    end

    egp_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (end_bad),
        .clr   (cnt_clr),
        .count (err_count)
    );

    AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R1
    AST_EDB_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        out_edb |-> out_last); // R4
    AST_MSG_NEEDS_EDB: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> (out_edb && out_last)); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_bad_q && in_valid && !in_sop) |=> pkt_bad_q); // R5
    AST_BAD_END_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (end_bad && !cnt_clr && err_count != {CNT_W{1'b1}}) |=> (err_count != $past(err_count))); // R7
endmodule

// File: tb/egress_parity_nullifier_bench.sv
// Bench for egress_parity_nullifier: directed corner cases plus seeded
// random packets, compared every cycle against a behavioural model.
module egress_parity_nullifier_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_par = 1'b0;
    logic [31:0] in_data = '0;
    logic        rpt_en = 1'b0, cnt_clr = 1'b0;
    logic        out_valid, out_sop, out_last, out_edb, msg_req;
    logic [31:0] out_data, out_crc;
    logic [15:0] err_count;

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_crc = 32'hFFFFFFFF;
    logic        m_bad = 1'b0;
    logic [15:0] m_cnt = '0;

    always #5 clk = ~clk;

    egress_parity_nullifier u_egress_parity_nullifier (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .in_par(in_par), .rpt_en(rpt_en),
        .cnt_clr(cnt_clr), .out_valid(out_valid), .out_sop(out_sop),
        .out_last(out_last), .out_data(out_data), .out_crc(out_crc),
        .out_edb(out_edb), .msg_req(msg_req), .err_count(err_count)
    );

    // Reference CRC step written from the requirement text (R3).
    function automatic logic [31:0] ref_crc(input logic [31:0] s, input logic [31:0] d);
        logic [31:0] c = s;
        for (int i = 0; i < 32; i++)
            c = (c >> 1) ^ ({32{c[0] ^ d[i]}} & 32'hEDB88320);
        return c;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, model, then compare after the edge.
    task automatic step(input bit v, input bit s, input bit e, input logic [31:0] d,
                        input bit corrupt, input bit rpt, input bit clr);
        logic [31:0] st, e_crc;
        bit bad, e_last, e_edb, e_msg, inc;
        @(negedge clk);
        in_valid = v; in_sop = s; in_eop = e; in_data = d;
        in_par = (^d) ^ corrupt;   // R2: even parity, flipped when corrupt
        rpt_en = rpt; cnt_clr = clr;
        st = s ? 32'hFFFFFFFF : m_crc;
        st = ref_crc(st, d);
        bad = (s ? 1'b0 : m_bad) | corrupt;
        e_last = v && e;
        e_edb = e_last && bad;
        e_crc = bad ? st : ~st;
        e_msg = e_edb && rpt;
        inc = e_edb;
        if (v) begin m_crc = st; m_bad = bad; end
        if (clr) m_cnt = '0;
        else if (inc && m_cnt != 16'hFFFF) m_cnt = m_cnt + 1'b1;
        @(posedge clk); #1;
        chk(out_valid == v, "R1 out_valid", 32'(out_valid), 32'(v));
        if (v) begin
            chk(out_data == d, "R1 out_data", out_data, d);
            chk(out_sop == s, "R1 out_sop", 32'(out_sop), 32'(s));
        end
        chk(out_last == e_last, "R1 out_last", 32'(out_last), 32'(e_last));
        if (e_last) begin
            chk(out_edb == e_edb, bad ? "R4 out_edb" : "R3 out_edb", 32'(out_edb), 32'(e_edb));
            chk(out_crc == e_crc, bad ? "R4 out_crc" : "R3 out_crc", out_crc, e_crc);
        end
        chk(msg_req == e_msg, "R6 msg_req", 32'(msg_req), 32'(e_msg));
        chk(err_count == m_cnt, clr ? "R9 err_count" : "R7 err_count", 32'(err_count), 32'(m_cnt));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk(out_valid == 0 && out_last == 0 && out_edb == 0, "R10 outputs", 32'(out_valid), 0);
        chk(msg_req == 0 && err_count == 0, "R10 msg/count", 32'(err_count), 0);
        @(negedge clk); rst_n = 1'b1;

        // R3: clean four-word packet
        step(1,1,0,32'h12345678,0,1,0); step(1,0,0,32'hDEADBEEF,0,1,0);
        step(1,0,0,32'h00000000,0,1,0); step(1,0,1,32'hFFFFFFFF,0,1,0);
        step(0,0,0,0,0,1,0);
        // R4/R7: several bad words, one request, one count step
        step(1,1,0,32'hA5A5A5A5,1,1,0); step(1,0,0,32'h0F0F0F0F,1,1,0);
        step(1,0,1,32'h11111111,1,1,0);
        // R5: clean packet right after a bad one
        step(1,1,0,32'h55AA55AA,0,1,0); step(1,0,1,32'h01020304,0,1,0);
        // R6: bad packet with reporting disabled
        step(1,1,0,32'hCAFEF00D,0,0,0); step(1,0,1,32'h0BADC0DE,1,0,0);
        // R9: clear coinciding with a bad single-word packet
        step(1,1,1,32'h77777777,1,1,1); step(1,1,1,32'h88888888,1,1,0);
        step(0,0,0,0,0,0,1);
        // R8: saturation by back-to-back bad single-word packets
        for (int i = 0; i < 65540; i++) step(1,1,1,32'(i),1,0,0);
        chk(err_count == 16'hFFFF, "R8 saturated", 32'(err_count), 32'hFFFF);
        step(0,0,0,0,0,0,1);
        // Random packets of 1..8 words with gaps and random corruption
        for (int p = 0; p < 300; p++) begin
            int len = 1 + ($urandom % 8);
            bit rpt = $urandom % 2;
            for (int w = 0; w < len; w++) begin
                step(1, w == 0, w == len - 1, $urandom, ($urandom % 10) == 0, rpt, ($urandom % 50) == 0);
                if (($urandom % 4) == 0) step(0,0,0,$urandom,0,rpt,0);
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule